// File: doc/BRIEF.md
# Motor PWM Shared Timebase

This block is the common time reference for a multi-channel motor PWM generator. It divides the bus clock by a selectable power of two to make a counter clock. A free-running period counter steps on that clock, and the per-channel duty comparators downstream read its value. Each time the counter wraps to zero, the block pulses a period-start strobe for one cycle. It also sets a sticky overflow flag, which drives the interrupt output.

Software reaches the block through one byte-wide control register on a simple address, write-enable and data bus. In the control register, software chooses:
- the divide ratio,
- a short (7-bit) or long (11-bit) period,
- a dither mode that lengthens every second period by one count,
- whether an external wait request stops the counter clock.

Changes to the divide ratio and to the period length are held back until the current period ends. A period is therefore never cut short or stretched part-way through.

Top module: `mtr_timebase`

## Requirements
- R1: While reset is asserted, the control register reads 0x00, `irq` is 0 and `tmr_count` is 0.
- R2: At the control address, `reg_rdata` is laid out as {0, prescale[1:0], stop_in_wait, short_mode, dither, 0, flag} (bit 7 down to bit 0). Written values of bits 6..2 read back unchanged. Bits 7 and 1 always read 0.
- R3: A period has 2048 counter clocks when short_mode=0 and 128 counter clocks when short_mode=1. `tmr_count` is 0 in the cycle when `period_start` is high. `period_start` is a single-cycle pulse, issued once per period.
- R4: Each counter clock lasts 2^prescale bus clocks (prescale 0,1,2,3 gives /1,/2,/4,/8).
- R5: A new prescale value written during a period takes effect only at the next period start.
- R6: A new short_mode value written during a period takes effect only at the next period start.
- R7: With dither=1, periods alternate between the nominal length and the nominal length plus one counter clock. The first period after dither is enabled is the longer one. With dither=0, every period has the nominal length.
- R8: The flag is set when the counter wraps, and `irq` equals the flag.
- R9: Writing 1 to bit 0 clears the flag, and writing 0 there leaves it unchanged. If a wrap and a clearing write fall on the same clock, the flag ends up set.
- R10: When stop_in_wait=1 and `wait_req`=1, the counter and prescaler freeze. When stop_in_wait=0, `wait_req` has no effect.
- R11: Writes to any address other than the control address change nothing. Reads from those addresses return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wait_req | input | 1 | Wait-mode request (clock gate when enabled) |
| reg_addr | input | ADDR_W | Register address |
| reg_we | input | 1 | Write enable |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational) |
| tmr_count | output | LONG_BITS+1 | Current counter value for the duty comparators |
| period_start | output | 1 | One-cycle pulse when a new period begins |
| irq | output | 1 | Overflow interrupt (follows the flag) |

## Verification
Suppose an active prescale or mode register picks up a written value early. The interval between consecutive `period_start` pulses then changes within the same period, instead of one period later. The bench measures every interval in bus clocks and compares it with 2^prescale × length, so such a fault shows up at the first boundary after the write. A wrong dither phase register gives a 129/128 alternation in the wrong order or none at all, and it appears within two periods. A flag that loses the collision with a clear shows as `irq` low in the cycle where `period_start` is high.

// File: rtl/mtbase_pkg.sv
`timescale 1ns/1ps
package mtbase_pkg;
   localparam int PRE_SEL_W = 2;
   localparam int NUM_PRE   = 1 << PRE_SEL_W;
   localparam int DIV_W     = NUM_PRE - 1;

   // bit positions inside the control byte
   localparam int B_FLAG  = 0;
   localparam int B_DITH  = 2;
   localparam int B_SHORT = 3;
   localparam int B_SWAI  = 4;
   localparam int B_PRE   = 5;

   typedef struct packed {
      logic [PRE_SEL_W-1:0] pre;
      logic                 swai;
      logic                 short_mode;
      logic                 dith;
   } mtb_cfg_t;
endpackage

// File: rtl/mtbase_ctrl.sv
`timescale 1ns/1ps
module mtbase_ctrl
   import mtbase_pkg::*;
#(
   parameter int ADDR_W    = 4,
   parameter int CTRL_ADDR = 0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_we,
   input  logic [7:0]        reg_wdata,
   input  logic              ovf_evt,
   output mtb_cfg_t          cfg,
   output logic              ovf_flag,
   output logic [7:0]        reg_rdata
);
   initial begin
      assert (ADDR_W >= 1) else $error("ADDR_W must be at least 1");
      assert (CTRL_ADDR >= 0 && CTRL_ADDR < (1 << ADDR_W))
         else $error("CTRL_ADDR outside address space");
   end

   logic sel, wr, clr_req;
   assign sel     = (reg_addr == ADDR_W'(CTRL_ADDR));
   assign wr      = sel && reg_we;
   assign clr_req = wr && reg_wdata[B_FLAG];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg <= '0;
      end else if (wr) begin
         cfg.pre        <= reg_wdata[B_PRE +: PRE_SEL_W];
         cfg.swai       <= reg_wdata[B_SWAI];
         cfg.short_mode <= reg_wdata[B_SHORT];
         cfg.dith       <= reg_wdata[B_DITH];
      end
   end

   // set has priority over a same-cycle clear
   always_ff @(posedge clk) begin
      if (!rst_n)       ovf_flag <= 1'b0;
      else if (ovf_evt) ovf_flag <= 1'b1;
      else if (clr_req) ovf_flag <= 1'b0;
   end

   always_comb begin
      reg_rdata = '0;
      if (sel) begin
         reg_rdata[B_PRE +: PRE_SEL_W] = cfg.pre;
         reg_rdata[B_SWAI]             = cfg.swai;
         reg_rdata[B_SHORT]            = cfg.short_mode;
         reg_rdata[B_DITH]             = cfg.dith;
         reg_rdata[B_FLAG]             = ovf_flag;
      end
   end

   a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_evt |=> ovf_flag);
   a_r9_zero_write_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (!ovf_evt && !clr_req) |=> $stable(ovf_flag));
   a_r11_foreign_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && !sel) |=> $stable(cfg));
endmodule

// File: rtl/mtbase_prescaler.sv
`timescale 1ns/1ps
module mtbase_prescaler
   import mtbase_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 run,
   input  logic [PRE_SEL_W-1:0] pre_act,
   output logic                 tick
);
   logic [DIV_W-1:0]   pdiv;
   logic [NUM_PRE-1:0] hit;

   // one terminal detector per ratio; ratio 2^i ends when the low i bits are all ones
   for (genvar i = 0; i < NUM_PRE; i++) begin : g_ratio
      localparam logic [DIV_W-1:0] MASK = DIV_W'((1 << i) - 1);
      assign hit[i] = (pre_act == PRE_SEL_W'(i)) && ((pdiv & MASK) == MASK);
   end

   assign tick = run && (|hit);

   always_ff @(posedge clk) begin
      if (!rst_n)      pdiv <= '0;
      else if (!run)   pdiv <= pdiv;
      else if (tick)   pdiv <= '0;
      else             pdiv <= pdiv + 1'b1;
   end

   a_r10_divider_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> $stable(pdiv));
endmodule

// File: rtl/mtbase_counter.sv
`timescale 1ns/1ps
module mtbase_counter
   import mtbase_pkg::*;
#(
   parameter int LONG_BITS  = 11,
   parameter int SHORT_BITS = 7,
   parameter bit DITHER_EN  = 1'b1,
   localparam int CW        = LONG_BITS + 1
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick,
   input  logic [PRE_SEL_W-1:0] pre_req,
   input  logic                 short_req,
   input  logic                 dith_req,
   output logic [CW-1:0]        cnt,
   output logic                 wrap,
   output logic [PRE_SEL_W-1:0] pre_act
);
   initial begin
      assert (SHORT_BITS >= 1 && SHORT_BITS < LONG_BITS)
         else $error("SHORT_BITS must be in 1..LONG_BITS-1");
   end

   localparam logic [CW-1:0] LONG_TERM  = CW'((1 << LONG_BITS) - 1);
   localparam logic [CW-1:0] SHORT_TERM = CW'((1 << SHORT_BITS) - 1);

   logic          short_act;
   logic          phase;
   logic [CW-1:0] term;

   if (DITHER_EN) begin : g_dith
      logic ph_q;
      always_ff @(posedge clk) begin
         if (!rst_n)    ph_q <= 1'b0;
         else if (wrap) ph_q <= dith_req ? ~ph_q : 1'b0;
      end
      assign phase = ph_q;
   end else begin : g_nodith
      assign phase = 1'b0 & dith_req;
   end

   assign term = (short_act ? SHORT_TERM : LONG_TERM) + CW'(phase);
   assign wrap = tick && (cnt == term);

   always_ff @(posedge clk) begin
      if (!rst_n)     cnt <= '0;
      else if (wrap)  cnt <= '0;
      else if (tick)  cnt <= cnt + 1'b1;
   end

   // configuration captured only at period boundaries
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pre_act   <= '0;
         short_act <= 1'b0;
      end else if (wrap) begin
         pre_act   <= pre_req;
         short_act <= short_req;
      end
   end

   a_r3_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(cnt));
   a_r3_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (cnt == '0));
   a_r5_pre_held_midperiod: assert property (@(posedge clk) disable iff (!rst_n)
      !wrap |=> $stable(pre_act));
   a_r6_mode_held_midperiod: assert property (@(posedge clk) disable iff (!rst_n)
      !wrap |=> $stable(short_act));
   a_r3_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LONG_TERM + 1'b1);
endmodule

// File: rtl/mtr_timebase.sv
`timescale 1ns/1ps
module mtr_timebase
   import mtbase_pkg::*;
#(
   parameter int ADDR_W     = 4,
   parameter int CTRL_ADDR  = 0,
   parameter int LONG_BITS  = 11,
   parameter int SHORT_BITS = 7,
   parameter bit DITHER_EN  = 1'b1
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wait_req,
   input  logic [ADDR_W-1:0]    reg_addr,
   input  logic                 reg_we,
   input  logic [7:0]           reg_wdata,
   output logic [7:0]           reg_rdata,
   output logic [LONG_BITS:0]   tmr_count,
   output logic                 period_start,
   output logic                 irq
);
   mtb_cfg_t             cfg;
   logic                 ovf_flag, wrap, tick, run;
   logic [PRE_SEL_W-1:0] pre_act;

   assign run = !(cfg.swai && wait_req);

   mtbase_ctrl #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
      .reg_wdata(reg_wdata), .ovf_evt(wrap), .cfg(cfg),
      .ovf_flag(ovf_flag), .reg_rdata(reg_rdata));

   mtbase_prescaler u_pre (
      .clk(clk), .rst_n(rst_n), .run(run), .pre_act(pre_act), .tick(tick));

   mtbase_counter #(.LONG_BITS(LONG_BITS), .SHORT_BITS(SHORT_BITS),
                    .DITHER_EN(DITHER_EN)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .pre_req(cfg.pre),
      .short_req(cfg.short_mode), .dith_req(cfg.dith), .cnt(tmr_count),
      .wrap(wrap), .pre_act(pre_act));

   always_ff @(posedge clk) begin
      if (!rst_n) period_start <= 1'b0;
      else        period_start <= wrap;
   end

   assign irq = ovf_flag;

   a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      period_start |=> !period_start);
   a_r8_flag_at_start: assert property (@(posedge clk) disable iff (!rst_n)
      period_start |-> irq);
   a_r10_frozen_in_wait: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> $stable(tmr_count));
endmodule

// File: tb/sim_mtr_timebase.sv
`timescale 1ns/1ps
module sim_mtr_timebase;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wait_req = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic        reg_we = 1'b0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic [11:0] tmr_count;
   logic        period_start, irq;

   int checks = 0, failures = 0;
   int cyc = 0, last_ps = 0, prev_ps = 0;

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   mtr_timebase u0 (.clk(clk), .rst_n(rst_n), .wait_req(wait_req),
      .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .tmr_count(tmr_count),
      .period_start(period_start), .irq(irq));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [7:0] cfgb(input int pre, input bit shrt,
                                       input bit dith, input bit swai);
      return {1'b0, pre[1:0], swai, shrt, dith, 2'b00};
   endfunction

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0; reg_addr = '0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] d);
      reg_addr = a; #1; d = reg_rdata; reg_addr = '0;
   endtask

   task automatic wait_ps();
      do @(negedge clk); while (!period_start);
      prev_ps = last_ps;
      last_ps = cyc;
   endtask

   initial begin
      #(4 * 190000);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [7:0] d;
      int c0, a, b;
      repeat (4) @(negedge clk);
      // R1 reset state
      rd(4'd0, d);
      chk(d == 8'h00, "R1 ctrl", d, 0);
      chk(irq == 1'b0, "R1 irq", irq, 0);
      chk(tmr_count == 0, "R1 count", tmr_count, 0);
      @(negedge clk);
      rst_n = 1'b1;

      // R3 long period, R8 flag
      wait_ps();
      chk(irq == 1'b1, "R8 irq at wrap", irq, 1);
      chk(tmr_count == 0, "R3 count zero at start", tmr_count, 0);
      wait_ps();
      chk(last_ps - prev_ps == 2048, "R3 long period", last_ps - prev_ps, 2048);

      // R2 readback, flag cleared by 1 write
      wr(4'd0, 8'hFF);
      rd(4'd0, d);
      chk(d == 8'h7C, "R2 readback", d, 8'h7C);
      wr(4'd0, 8'h00);
      rd(4'd0, d);
      chk(d == 8'h00, "R2 readback zero", d, 0);
      // R11 foreign address
      wr(4'd5, 8'hFF);
      rd(4'd0, d);
      chk(d == 8'h00, "R11 ctrl untouched", d, 0);
      rd(4'd5, d);
      chk(d == 8'h00, "R11 read zero", d, 0);

      // R9 write-0 keeps, write-1 clears
      wait_ps();
      wr(4'd0, 8'h00);
      chk(irq == 1'b1, "R9 zero write keeps", irq, 1);
      wr(4'd0, 8'h01);
      chk(irq == 1'b0, "R9 one write clears", irq, 0);

      // R4 short mode, all prescalers
      for (int p = 0; p < 4; p++) begin
         wr(4'd0, cfgb(p, 1'b1, 1'b0, 1'b0));
         wait_ps();
         wait_ps();
         chk(last_ps - prev_ps == (128 << p), "R4 short prescale",
             last_ps - prev_ps, 128 << p);
      end

      // R5 prescaler deferred
      wr(4'd0, cfgb(0, 1'b1, 1'b0, 1'b0));
      wait_ps();
      chk(last_ps - prev_ps == 1024, "R5 old ratio kept", last_ps - prev_ps, 1024);
      wait_ps();
      chk(last_ps - prev_ps == 128, "R5 new ratio applied", last_ps - prev_ps, 128);

      // R6 mode deferred
      wr(4'd0, cfgb(0, 1'b0, 1'b0, 1'b0));
      wait_ps();
      chk(last_ps - prev_ps == 128, "R6 old mode kept", last_ps - prev_ps, 128);
      wait_ps();
      chk(last_ps - prev_ps == 2048, "R6 new mode applied", last_ps - prev_ps, 2048);
      wr(4'd0, cfgb(1, 1'b0, 1'b0, 1'b0));
      wait_ps();
      wait_ps();
      chk(last_ps - prev_ps == 4096, "R4 long div2", last_ps - prev_ps, 4096);

      // R7 dither
      wr(4'd0, cfgb(0, 1'b1, 1'b1, 1'b0));
      wait_ps();
      for (int k = 0; k < 4; k++) begin
         wait_ps();
         chk(last_ps - prev_ps == ((k % 2 == 0) ? 129 : 128), "R7 dither alternation",
             last_ps - prev_ps, (k % 2 == 0) ? 129 : 128);
      end
      wr(4'd0, cfgb(0, 1'b1, 1'b0, 1'b0));
      wait_ps();
      wait_ps(); a = last_ps - prev_ps;
      wait_ps(); b = last_ps - prev_ps;
      chk(a == 128 && b == 128, "R7 no dither", a + b, 256);

      // R9 collision of wrap and clear
      wait_ps();
      wr(4'd0, cfgb(0, 1'b1, 1'b0, 1'b0) | 8'h01);
      chk(irq == 1'b0, "R9 cleared", irq, 0);
      repeat (126) @(negedge clk);
      reg_addr = 4'd0; reg_wdata = cfgb(0, 1'b1, 1'b0, 1'b0) | 8'h01; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
      chk(period_start == 1'b1, "R9 collision timing", period_start, 1);
      chk(irq == 1'b1, "R9 set wins", irq, 1);

      // R10 stop in wait
      wr(4'd0, cfgb(0, 1'b1, 1'b0, 1'b1));
      wait_req = 1'b1;
      @(negedge clk);
      c0 = tmr_count;
      a = 0;
      repeat (50) begin
         @(negedge clk);
         if (period_start) a++;
      end
      chk(tmr_count == c0 && a == 0, "R10 frozen", tmr_count, c0);
      wait_req = 1'b0;
      repeat (5) @(negedge clk);
      chk(tmr_count == ((c0 + 5) & 127), "R10 resumes", tmr_count, (c0 + 5) & 127);
      wr(4'd0, cfgb(0, 1'b1, 1'b0, 1'b0));
      wait_req = 1'b1;
      wait_ps();
      wait_ps();
      chk(last_ps - prev_ps == 128, "R10 wait ignored", last_ps - prev_ps, 128);
      wait_req = 1'b0;

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule